// File: doc/BRIEF.md
# Serial Peripheral Interrupt Aggregator

This block collects the interrupt conditions of a serial peripheral into one register-visible status word and one level interrupt line. The FIFOs and the transfer engine hand it single-cycle event pulses (receive overrun, transmit half-empty, transmit underrun, transmit empty) and two level conditions (receive holds data, receive is full). Each condition is latched into a sticky status bit. Software reaches the status, the per-bit enable mask and a master enable through a plain 32-bit register port with byte addresses.

The status word uses toggle semantics. Writing a value flips every defined status bit that is 1 in the value. Software therefore clears a bit by writing back the value it just read. The two receive level flags are asserted again on every clock while their condition is present. A write can clear them only once the FIFO condition has gone away. The interrupt line is registered. It is high when any enabled status bit is set and the master enable is on.

The block knows nothing about serial timing or FIFO storage. It only sees condition wires and register accesses.

Top module: `spi_irq_agg`

## Requirements
- R1: After reset the status, enable and master-enable registers all read 0 and `irqOut` is 0.
- R2: The master enable sits at byte address 0x1C and holds only bit 31. Its other bits read 0. The enable mask sits at 0x28 and the status word at 0x20. Read data is combinational from the addressed register.
- R3: Status bit positions are: receive-not-empty 8, receive-full 4, receive-overrun 5, transmit-half-empty 6, transmit-underrun 3, transmit-empty 2. A pulse on an event input sets its bit at the next clock edge. The bit then stays set until software changes it.
- R4: A write to 0x20 XORs the written data into the defined status bits.
- R5: While `lvlRxNotEmpty` (bit 8) or `lvlRxFull` (bit 4) is high, its bit is set again on every clock. A toggle write cannot clear it while the level holds. Once the level is low, a toggle write clears it.
- R6: When a status write and a hardware condition hit the same bit in the same cycle, the bit ends up set. Other bits written in that cycle toggle as usual.
- R7: `irqOut` equals (status AND enable is non-zero) AND master enable, as registered at the clock edge after those registers change.
- R8: Status and enable bits outside the six defined positions always read 0, whatever is written to them.
- R9: A write to any other address changes no register. A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | ADDR_W | Byte address of the access |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data for `regAddr` |
| evtRxOverrun | input | 1 | Pulse: a received word was dropped |
| evtTxHalfEmpty | input | 1 | Pulse: transmit FIFO reached half empty |
| evtTxUnderrun | input | 1 | Pulse: transmit FIFO ran dry during a transfer |
| evtTxEmpty | input | 1 | Pulse: transmit FIFO became empty |
| lvlRxNotEmpty | input | 1 | Level: receive FIFO holds data |
| lvlRxFull | input | 1 | Level: receive FIFO is full |
| irqOut | output | 1 | Registered level interrupt |

## Verification
The assertions assume that each register write lasts a single cycle, with address and data stable in that cycle. They also assume that event inputs are synchronous to `clk` and that the toggle and hold properties apply only in cycles where no condition input is active. The bench drives every input at the falling edge and keeps writes one cycle long. It holds all condition inputs low during the toggle sweep. Conditions are raised together with writes only in the cycles meant to test collisions, so the quiet-cycle premises hold wherever they are meant to bite.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Status bit positions; software decodes these, so they are fixed.
  localparam int BIT_RX_NEMPTY  = 8;
  localparam int BIT_TX_HALF    = 6;
  localparam int BIT_RX_OVR     = 5;
  localparam int BIT_RX_FULL    = 4;
  localparam int BIT_TX_UNDER   = 3;
  localparam int BIT_TX_EMPTY   = 2;

  localparam logic [31:0] STS_IMPL_MASK =
      (32'd1 << BIT_RX_NEMPTY) | (32'd1 << BIT_TX_HALF) |
      (32'd1 << BIT_RX_OVR)    | (32'd1 << BIT_RX_FULL) |
      (32'd1 << BIT_TX_UNDER)  | (32'd1 << BIT_TX_EMPTY);

  typedef struct packed {
    logic wrGlobal;
    logic wrStatus;
    logic wrEnable;
  } irq_strobe_t;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_GLOBAL = 2'd1,
    RD_STATUS = 2'd2,
    RD_ENABLE = 2'd3
  } irq_rdsel_t;

endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] GLB_OFFS = 'h1C,
  parameter logic [ADDR_W-1:0] STS_OFFS = 'h20,
  parameter logic [ADDR_W-1:0] IEN_OFFS = 'h28
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output irq_strobe_t       strb,
  output irq_rdsel_t        rdSel
);

  logic hitGlb, hitSts, hitIen;

  assign hitGlb = (regAddr == GLB_OFFS);
  assign hitSts = (regAddr == STS_OFFS);
  assign hitIen = (regAddr == IEN_OFFS);

  always_comb begin
    strb.wrGlobal = regWrEn && hitGlb;
    strb.wrStatus = regWrEn && hitSts;
    strb.wrEnable = regWrEn && hitIen;
  end

  always_comb begin
    if (hitGlb)      rdSel = RD_GLOBAL;
    else if (hitSts) rdSel = RD_STATUS;
    else if (hitIen) rdSel = RD_ENABLE;
    else             rdSel = RD_NONE;
  end

endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  irq_strobe_t       strb,
  input  irq_rdsel_t        rdSel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              evtRxOverrun,
  input  logic              evtTxHalfEmpty,
  input  logic              evtTxUnderrun,
  input  logic              evtTxEmpty,
  input  logic              lvlRxNotEmpty,
  input  logic              lvlRxFull,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic [DATA_W-1:0] statusQ,
  output logic [DATA_W-1:0] enableQ,
  output logic              gieQ
);

  localparam int GIE_BIT = DATA_W - 1;
  localparam logic [DATA_W-1:0] MASK    = DATA_W'(STS_IMPL_MASK);
  localparam logic [DATA_W-1:0] GIE_ONE = DATA_W'(1) << GIE_BIT;

  logic [DATA_W-1:0] hwSet;

  // Hardware conditions as a set vector; levels re-latch every cycle.
  always_comb begin
    hwSet                = '0;
    hwSet[BIT_RX_NEMPTY] = lvlRxNotEmpty;
    hwSet[BIT_RX_FULL]   = lvlRxFull;
    hwSet[BIT_RX_OVR]    = evtRxOverrun;
    hwSet[BIT_TX_HALF]   = evtTxHalfEmpty;
    hwSet[BIT_TX_UNDER]  = evtTxUnderrun;
    hwSet[BIT_TX_EMPTY]  = evtTxEmpty;
  end

  logic unusedBits;
  assign unusedBits = ^{hwSet & ~MASK, wdata & ~(MASK | GIE_ONE)};

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (MASK[i]) begin : g_impl
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          statusQ[i] <= 1'b0;
          enableQ[i] <= 1'b0;
        end else begin
          // toggle by software, then hardware set takes priority
          statusQ[i] <= (statusQ[i] ^ (strb.wrStatus & wdata[i])) | hwSet[i];
          if (strb.wrEnable) enableQ[i] <= wdata[i];
        end
      end
    end else begin : g_tie
      assign statusQ[i] = 1'b0;
      assign enableQ[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              gieQ <= 1'b0;
    else if (strb.wrGlobal) gieQ <= wdata[GIE_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= (|(statusQ & enableQ)) & gieQ;
  end

  always_comb begin
    unique case (rdSel)
      RD_GLOBAL: rdData = gieQ ? GIE_ONE : '0;
      RD_STATUS: rdData = statusQ;
      RD_ENABLE: rdData = enableQ;
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/spi_irq_agg.sv
module spi_irq_agg
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] GLB_OFFS = 'h1C,
  parameter logic [ADDR_W-1:0] STS_OFFS = 'h20,
  parameter logic [ADDR_W-1:0] IEN_OFFS = 'h28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              evtRxOverrun,
  input  logic              evtTxHalfEmpty,
  input  logic              evtTxUnderrun,
  input  logic              evtTxEmpty,
  input  logic              lvlRxNotEmpty,
  input  logic              lvlRxFull,
  output logic              irqOut
);

  irq_strobe_t       strb;
  irq_rdsel_t        rdSel;
  logic [DATA_W-1:0] statusQ;
  logic [DATA_W-1:0] enableQ;
  logic              gieQ;

  irq_agg_ctrl #(
    .ADDR_W(ADDR_W), .GLB_OFFS(GLB_OFFS), .STS_OFFS(STS_OFFS), .IEN_OFFS(IEN_OFFS)
  ) u_ctrl (
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .strb   (strb),
    .rdSel  (rdSel)
  );

  irq_agg_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .rdSel         (rdSel),
    .wdata         (regWrData),
    .evtRxOverrun  (evtRxOverrun),
    .evtTxHalfEmpty(evtTxHalfEmpty),
    .evtTxUnderrun (evtTxUnderrun),
    .evtTxEmpty    (evtTxEmpty),
    .lvlRxNotEmpty (lvlRxNotEmpty),
    .lvlRxFull     (lvlRxFull),
    .rdData        (regRdData),
    .irqOut        (irqOut),
    .statusQ       (statusQ),
    .enableQ       (enableQ),
    .gieQ          (gieQ)
  );

endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] GLB_OFFS = 'h1C,
  parameter logic [ADDR_W-1:0] STS_OFFS = 'h20,
  parameter logic [ADDR_W-1:0] IEN_OFFS = 'h28
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              evtRxOverrun,
  input logic              evtTxHalfEmpty,
  input logic              evtTxUnderrun,
  input logic              evtTxEmpty,
  input logic              lvlRxNotEmpty,
  input logic              lvlRxFull,
  input logic              irqOut,
  input logic [DATA_W-1:0] statusQ,
  input logic [DATA_W-1:0] enableQ,
  input logic              gieQ
);

  localparam logic [DATA_W-1:0] MASK = DATA_W'(STS_IMPL_MASK);

  logic anyHw, stsWr, glbWr, mapped;
  assign anyHw  = evtRxOverrun | evtTxHalfEmpty | evtTxUnderrun | evtTxEmpty |
                  lvlRxNotEmpty | lvlRxFull;
  assign stsWr  = regWrEn && (regAddr == STS_OFFS);
  assign glbWr  = regWrEn && (regAddr == GLB_OFFS);
  assign mapped = (regAddr == GLB_OFFS) || (regAddr == STS_OFFS) || (regAddr == IEN_OFFS);

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past((|(statusQ & enableQ)) && gieQ))); // R7
  AST_TX_EMPTY_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    evtTxEmpty |=> statusQ[BIT_TX_EMPTY]); // R3
  AST_RX_NEMPTY_RELATCH: assert property (@(posedge clk) disable iff (!rstN)
    lvlRxNotEmpty |=> statusQ[BIT_RX_NEMPTY]); // R5
  AST_RX_FULL_RELATCH: assert property (@(posedge clk) disable iff (!rstN)
    lvlRxFull |=> statusQ[BIT_RX_FULL]); // R5
  AST_STATUS_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (stsWr && !anyHw) |=> (statusQ == $past(statusQ ^ (regWrData & MASK)))); // R4
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stsWr && !anyHw) |=> $stable(statusQ)); // R3
  AST_COLLIDE_SET: assert property (@(posedge clk) disable iff (!rstN)
    (stsWr && evtRxOverrun) |=> statusQ[BIT_RX_OVR]); // R6
  AST_GIE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    glbWr |=> (gieQ == $past(regWrData[DATA_W-1]))); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> (regRdData == '0)); // R9
  AST_ENABLE_UNDEFINED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((enableQ & ~MASK) == '0)); // R8

endmodule

bind spi_irq_agg irq_agg_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .GLB_OFFS(GLB_OFFS), .STS_OFFS(STS_OFFS), .IEN_OFFS(IEN_OFFS)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .regWrEn       (regWrEn),
  .regAddr       (regAddr),
  .regWrData     (regWrData),
  .regRdData     (regRdData),
  .evtRxOverrun  (evtRxOverrun),
  .evtTxHalfEmpty(evtTxHalfEmpty),
  .evtTxUnderrun (evtTxUnderrun),
  .evtTxEmpty    (evtTxEmpty),
  .lvlRxNotEmpty (lvlRxNotEmpty),
  .lvlRxFull     (lvlRxFull),
  .irqOut        (irqOut),
  .statusQ       (statusQ),
  .enableQ       (enableQ),
  .gieQ          (gieQ)
);

// File: tb/spi_irq_agg_tb.sv
module spi_irq_agg_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_GLB = 8'h1C;
  localparam logic [7:0] A_STS = 8'h20;
  localparam logic [7:0] A_IEN = 8'h28;
  localparam logic [31:0] MASK = 32'h0000_017C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        evtRxOverrun = 1'b0, evtTxHalfEmpty = 1'b0;
  logic        evtTxUnderrun = 1'b0, evtTxEmpty = 1'b0;
  logic        lvlRxNotEmpty = 1'b0, lvlRxFull = 1'b0;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int posTab[6] = '{8, 4, 5, 6, 3, 2};

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_irq_agg u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .evtRxOverrun(evtRxOverrun), .evtTxHalfEmpty(evtTxHalfEmpty),
    .evtTxUnderrun(evtTxUnderrun), .evtTxEmpty(evtTxEmpty),
    .lvlRxNotEmpty(lvlRxNotEmpty), .lvlRxFull(lvlRxFull), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic clearStatus();
    logic [31:0] v;
    rdReg(A_STS, v);
    wrReg(A_STS, v);
  endtask

  task automatic pulseEvt(input int which);
    @(negedge clk);
    case (which)
      0: evtRxOverrun = 1'b1;
      1: evtTxHalfEmpty = 1'b1;
      2: evtTxUnderrun = 1'b1;
      default: evtTxEmpty = 1'b1;
    endcase
    @(negedge clk);
    evtRxOverrun = 1'b0; evtTxHalfEmpty = 1'b0;
    evtTxUnderrun = 1'b0; evtTxEmpty = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] expSts;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    rdReg(A_GLB, v); check("R1 global", v, 32'h0);
    rdReg(A_STS, v); check("R1 status", v, 32'h0);
    rdReg(A_IEN, v); check("R1 enable", v, 32'h0);
    check("R1 irq", {31'b0, irqOut}, 32'h0);

    // R2/R8: map and widths
    wrReg(A_GLB, 32'hFFFF_FFFF); rdReg(A_GLB, v); check("R2 global bit31 only", v, 32'h8000_0000);
    wrReg(A_GLB, 32'h7FFF_FFFF); rdReg(A_GLB, v); check("R2 global cleared", v, 32'h0);
    wrReg(A_IEN, 32'hFFFF_FFFF); rdReg(A_IEN, v); check("R8 enable defined bits", v, MASK);
    wrReg(A_IEN, 32'h0);         rdReg(A_IEN, v); check("R2 enable cleared", v, 32'h0);

    // R9: other addresses
    foreach (posTab[k]) begin end
    for (int a = 0; a < 64; a += 1) begin
      logic [7:0] ad;
      ad = 8'(a);
      if (ad == A_GLB || ad == A_STS || ad == A_IEN) continue;
      wrReg(ad, 32'hFFFF_FFFF);
      rdReg(ad, v); check("R9 unmapped read", v, 32'h0);
    end
    rdReg(A_GLB, v); check("R9 global untouched", v, 32'h0);
    rdReg(A_STS, v); check("R9 status untouched", v, 32'h0);
    rdReg(A_IEN, v); check("R9 enable untouched", v, 32'h0);

    // R3: event pulses set and stick
    for (int e = 0; e < 4; e++) begin
      int bp;
      bp = (e == 0) ? 5 : (e == 1) ? 6 : (e == 2) ? 3 : 2;
      pulseEvt(e);
      repeat (3) @(negedge clk);
      rdReg(A_STS, v); check("R3 event sticky", v, 32'h1 << bp);
      clearStatus();
      rdReg(A_STS, v); check("R4 clear by writeback", v, 32'h0);
    end
    // R3: level pulses stay latched after the level drops
    @(negedge clk); lvlRxNotEmpty = 1'b1; lvlRxFull = 1'b1;
    @(negedge clk); lvlRxNotEmpty = 1'b0; lvlRxFull = 1'b0;
    repeat (2) @(negedge clk);
    rdReg(A_STS, v); check("R3 level bits latched", v, 32'h0000_0110);
    clearStatus();

    // R4/R8: toggle sweep over all 64 combinations of the defined bits
    expSts = '0;
    for (int c = 0; c < 64; c++) begin
      logic [31:0] w;
      w = 32'hFFFF_FE83 & ~MASK;
      for (int b = 0; b < 6; b++) if (c[b]) w |= 32'h1 << posTab[b];
      wrReg(A_STS, w);
      expSts ^= (w & MASK);
      rdReg(A_STS, v); check("R4 toggle sweep", v, expSts);
    end
    wrReg(A_STS, 32'hFFFF_FFFF); expSts ^= MASK;
    rdReg(A_STS, v); check("R8 status undefined bits", v, expSts);
    clearStatus();

    // R5: levels re-latch against toggle writes
    @(negedge clk); lvlRxNotEmpty = 1'b1; lvlRxFull = 1'b1;
    @(negedge clk);
    wrReg(A_STS, 32'h0000_0110);
    rdReg(A_STS, v); check("R5 held levels resist toggle", v, 32'h0000_0110);
    lvlRxNotEmpty = 1'b0; lvlRxFull = 1'b0;
    @(negedge clk);
    wrReg(A_STS, 32'h0000_0100);
    rdReg(A_STS, v); check("R5 rx-not-empty clears after level drops", v, 32'h0000_0010);
    wrReg(A_STS, 32'h0000_0010);
    rdReg(A_STS, v); check("R5 rx-full clears after level drops", v, 32'h0);

    // R6: collision, bit5 and bit3 set, then toggle both while overrun pulses
    wrReg(A_STS, 32'h0000_0028);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = A_STS; regWrData = 32'h0000_0028; evtRxOverrun = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0; evtRxOverrun = 1'b0;
    rdReg(A_STS, v); check("R6 hardware wins collision", v, 32'h0000_0020);
    clearStatus();

    // R7: irq sweep over bit, enable pattern and master enable
    for (int b = 0; b < 6; b++) begin
      for (int es = 0; es < 3; es++) begin
        for (int g = 0; g < 2; g++) begin
          logic [31:0] en;
          logic expIrq;
          en = (es == 0) ? 32'h0 : (es == 1) ? (32'h1 << posTab[b])
                                             : (32'h1 << posTab[(b + 1) % 6]);
          clearStatus();
          wrReg(A_IEN, en);
          wrReg(A_GLB, g ? 32'h8000_0000 : 32'h0);
          @(negedge clk);
          check("R7 irq low before status set", {31'b0, irqOut}, 32'h0);
          wrReg(A_STS, 32'h1 << posTab[b]);
          check("R7 irq registered one cycle late", {31'b0, irqOut}, 32'h0);
          @(negedge clk);
          expIrq = (es == 1) && (g == 1);
          check("R7 irq level", {31'b0, irqOut}, {31'b0, expIrq});
        end
      end
    end
    wrReg(A_GLB, 32'h0);
    @(negedge clk);
    check("R7 irq drops with master enable", {31'b0, irqOut}, 32'h0);

    finishRun();
  end

endmodule